// File: doc/BRIEF.md
# I2C Register-Bank Target

This block lets an external I2C controller read and write a small bank of 8-bit registers. The bus lines SCL and SDA come in asynchronously; the block brings them into the system clock domain and follows the bus state itself. SDA is driven open-drain through a single output-enable, where 1 pulls the line low. The block answers one fixed 7-bit device address and addresses its registers through one shared index called the pointer.

A write transaction carries the pointer value as its first byte, followed by any number of data bytes. These fill consecutive registers. A read returns the register under the pointer and keeps going while the controller acknowledges. The usual read is combined: a write that sets the pointer, a repeated START, then the device address with the read direction. Every byte moved in either direction advances the pointer. The pointer wraps at the end of the bank and is kept from one transaction to the next.

Top module: `i2c_regbank_target`

## Requirements
- R1: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high), seen at any moment, ends the byte in progress and releases SDA (sda_oe = 0). After a START the block expects an address byte.
- R2: The address byte has seven address bits, MSB first, followed by a direction bit (0 = write, 1 = read). When the seven bits equal DEV_ADDR (default 0x2C), the block holds SDA low during the ninth clock.
- R3: When the address does not match, the block leaves SDA released and ignores every following bit until the next START or STOP. No register and no pointer changes.
- R4: In a write, the first byte after the address is acknowledged and its low log2(NUM_REGS) bits are loaded into the pointer.
- R5: Each later byte of a write is acknowledged and stored in the register the pointer selects. The pointer then advances by one and wraps from NUM_REGS-1 to 0.
- R6: After a matched read address is acknowledged, the block sends the selected register MSB first and advances the pointer after each byte it sends.
- R7: When the controller acknowledges a sent byte, the next register follows at once. When it does not acknowledge, the block releases SDA and stays silent until START or STOP.
- R8: The block raises its SDA drive only while SCL is low. It samples received bits on the rising edge of SCL.
- R9: A write to an index set in RO_MASK (default: index 7 only) is acknowledged but discarded. Such a register always reads as RO_BASE plus its index (default 0xC7 for index 7).
- R10: After reset, sda_oe is 0, every writable register holds 0x00 and the pointer is 0. A STOP leaves the pointer unchanged, so a read with no pointer write starts where the last transaction left off.
- R11: A START that arrives partway through a data byte discards that byte. No register is written and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad (asynchronous) |
| sda_i | input | 1 | Bus data line as seen at the pad (asynchronous) |
| sda_oe | output | 1 | Data-line pull-down enable; 1 drives SDA low |

## Verification
The hardest situations to reach from the pins are a repeated START that cuts a data byte short, and a burst write that runs across a read-only index and wraps to index 0. The bench bit-bangs the bus. It sets the pointer, shifts only half of a data byte, issues a repeated START and reads back the same index, which shows that neither the register nor the pointer moved. For the second case it starts a burst write two registers before the end of the bank and reads the span back across the wrap. A further sequence sends a wrong address followed by data bytes, then reads with no pointer write to show that the ignored traffic left the pointer and the registers untouched.

// File: rtl/i2c_rb_pkg.sv
// Package: shared types for the I2C register-bank target.
// Assumes: nothing beyond the standard language.
package i2c_rb_pkg;

    // Byte-engine states: receive phases, acknowledge slot, transmit, controller acknowledge.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_REG,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_MACK
    } eng_state_t;

endpackage

// File: rtl/i2c_rb_lines.sv
// Module: i2c_rb_lines
// Brings SCL and SDA into the clk domain through two flops each. From the
// synchronised lines it derives single-cycle pulses for SCL edges and for bus
// START and STOP conditions.
// Assumes: clk is several times faster than SCL; both lines idle high.
module i2c_rb_lines (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_m, sda_m;
    logic scl_q, sda_q;

    // Two-flop synchroniser plus one history stage for each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            sda_m <= 1'b1;
            scl_s <= 1'b1;
            sda_s <= 1'b1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_m <= scl_i;
            sda_m <= sda_i;
            scl_s <= scl_m;
            sda_s <= sda_m;
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and bus-condition decode from the current and previous samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_rb_regfile.sv
// Module: i2c_rb_regfile
// Bank of NUM_REGS byte registers with one write port and one combinational
// read port. An index whose RO_MASK bit is set is a constant
// (RO_BASE + index), and writes to it have no effect.
// Assumes: NUM_REGS is a power of two; the caller never presents an index
// outside the bank.
module i2c_rb_regfile #(
    parameter int                     NUM_REGS = 8,
    parameter int                     PTR_W    = $clog2(NUM_REGS),
    parameter logic [NUM_REGS-1:0]    RO_MASK  = '0,
    parameter logic [7:0]             RO_BASE  = 8'hC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [7:0]       rdata
);

    logic [7:0] cells [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
        if (RO_MASK[i]) begin : g_ro
            // Read-only index: constant value derived from its position.
            assign cells[i] = RO_BASE + 8'(i);
        end else begin : g_rw
            logic [7:0] store;
            // Writable index: cleared by reset, loaded on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    store <= 8'h00;
                else if (we && waddr == PTR_W'(i))
                    store <= wdata;
            end
            assign cells[i] = store;
        end
    end

    // Read port: selected cell.
    always_comb rdata = cells[raddr];

endmodule

// File: rtl/i2c_rb_engine.sv
// Module: i2c_rb_engine
// Byte-level protocol engine. It shifts in address and data bits on SCL
// rising edges and decides on the acknowledge. It owns the register pointer,
// issues register writes and shifts out read data, changing its drive only
// after SCL falls.
// Assumes: inputs come from i2c_rb_lines; rd_data is the register at ptr,
// available in the same cycle.
module i2c_rb_engine
    import i2c_rb_pkg::*;
#(
    parameter int         NUM_REGS = 8,
    parameter int         PTR_W    = $clog2(NUM_REGS),
    parameter logic [6:0] DEV_ADDR = 7'h2C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    output logic             sda_oe,
    output logic [PTR_W-1:0] ptr,
    output logic             reg_we,
    output logic [PTR_W-1:0] reg_waddr,
    output logic [7:0]       reg_wdata
);

    eng_state_t state, ack_next;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic [2:0] bit_cnt;
    logic       ack_drv;
    logic       m_seen;
    logic       m_ack;
    logic [7:0] rx_byte;

    // Complete byte as it stands once the current bit is shifted in.
    always_comb rx_byte = {rx_sh, sda_s};

    // Next pointer value, wrapping at the end of the bank.
    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NUM_REGS - 1)) ? '0 : p + 1'b1;
    endfunction

    // Protocol state machine, shifters, pointer and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ack_next  <= ST_IDLE;
            rx_sh     <= '0;
            tx_sh     <= '0;
            bit_cnt   <= '0;
            ack_drv   <= 1'b0;
            m_seen    <= 1'b0;
            m_ack     <= 1'b0;
            sda_oe    <= 1'b0;
            ptr       <= '0;
            reg_we    <= 1'b0;
            reg_waddr <= '0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                ack_drv <= 1'b0;
                m_seen  <= 1'b0;
            end else if (stop_det) begin
                state   <= ST_IDLE;
                sda_oe  <= 1'b0;
                ack_drv <= 1'b0;
                m_seen  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_REG, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh   <= rx_byte[6:0];
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 3'd7) begin
                                if (state == ST_ADDR) begin
                                    if (rx_byte[7:1] == DEV_ADDR) begin
                                        state    <= ST_ACK;
                                        ack_next <= rx_byte[0] ? ST_TX : ST_REG;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end else if (state == ST_REG) begin
                                    ptr      <= rx_byte[PTR_W-1:0];
                                    state    <= ST_ACK;
                                    ack_next <= ST_WDATA;
                                end else begin
                                    reg_we    <= 1'b1;
                                    reg_waddr <= ptr;
                                    reg_wdata <= rx_byte;
                                    ptr       <= ptr_inc(ptr);
                                    state     <= ST_ACK;
                                    ack_next  <= ST_WDATA;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (!ack_drv) begin
                                sda_oe  <= 1'b1;
                                ack_drv <= 1'b1;
                            end else begin
                                ack_drv <= 1'b0;
                                state   <= ack_next;
                                bit_cnt <= '0;
                                if (ack_next == ST_TX) begin
                                    tx_sh  <= rd_data;
                                    sda_oe <= ~rd_data[7];
                                end else begin
                                    sda_oe <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 3'd7) begin
                                ptr    <= ptr_inc(ptr);
                                state  <= ST_MACK;
                                m_seen <= 1'b0;
                            end
                        end else if (scl_fall) begin
                            tx_sh  <= {tx_sh[6:0], 1'b0};
                            sda_oe <= ~tx_sh[6];
                        end
                    end
                    ST_MACK: begin
                        if (scl_fall && !m_seen) begin
                            sda_oe <= 1'b0;
                        end else if (scl_rise) begin
                            m_ack  <= ~sda_s;
                            m_seen <= 1'b1;
                        end else if (scl_fall) begin
                            m_seen <= 1'b0;
                            if (m_ack) begin
                                state   <= ST_TX;
                                bit_cnt <= '0;
                                tx_sh   <= rd_data;
                                sda_oe  <= ~rd_data[7];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_regbank_target.sv
// Module: i2c_regbank_target
// I2C target giving a bus controller pointer-based access to a byte register
// bank. It chains the line conditioner, the protocol engine and the register
// array.
// Assumes: NUM_REGS is a power of two; SDA is open-drain and sda_oe = 1
// pulls it low.
module i2c_regbank_target #(
    parameter int                  NUM_REGS = 8,
    parameter logic [6:0]          DEV_ADDR = 7'h2C,
    parameter logic [NUM_REGS-1:0] RO_MASK  = NUM_REGS'(1) << (NUM_REGS - 1),
    parameter logic [7:0]          RO_BASE  = 8'hC0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    localparam int PTR_W = $clog2(NUM_REGS);

    logic             scl_s, sda_s;
    logic             scl_rise, scl_fall, start_det, stop_det;
    logic [PTR_W-1:0] ptr;
    logic             reg_we;
    logic [PTR_W-1:0] reg_waddr;
    logic [7:0]       reg_wdata;
    logic [7:0]       rd_data;

    i2c_rb_lines u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rb_engine #(
        .NUM_REGS (NUM_REGS),
        .PTR_W    (PTR_W),
        .DEV_ADDR (DEV_ADDR)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .ptr       (ptr),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata)
    );

    i2c_rb_regfile #(
        .NUM_REGS (NUM_REGS),
        .PTR_W    (PTR_W),
        .RO_MASK  (RO_MASK),
        .RO_BASE  (RO_BASE)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (reg_waddr),
        .wdata (reg_wdata),
        .raddr (ptr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/i2c_rb_checker.sv
// Module: i2c_rb_checker
// Protocol properties for i2c_regbank_target, attached through bind.
// Assumes: signals are sampled on clk; rst_n is synchronous and active low.
module i2c_rb_checker #(
    parameter int NUM_REGS = 8,
    parameter int PTR_W    = $clog2(NUM_REGS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_oe,
    input logic             start_det,
    input logic             stop_det,
    input logic             reg_we,
    input logic [PTR_W-1:0] reg_waddr,
    input logic [PTR_W-1:0] ptr
);

    // R8: the pull-down is switched on only while synchronised SCL is low.
    a_r8_drive_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s));

    // R1: a STOP releases the data line on the next cycle.
    a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R1: a START releases the data line on the next cycle.
    a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R5: each received data byte gives exactly one write strobe.
    a_r5_single_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R5: after a write, the pointer sits one past the written index, wrapping.
    a_r5_ptr_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ptr == ((reg_waddr == PTR_W'(NUM_REGS - 1)) ? '0 : reg_waddr + 1'b1));

endmodule

bind i2c_regbank_target i2c_rb_checker #(
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe),
    .start_det (start_det),
    .stop_det  (stop_det),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .ptr       (ptr)
);

// File: tb/i2c_regbank_target_bench.sv
`timescale 1ns/1ps
// Bench: bit-banged bus controller. The driver tasks push expected bytes and
// acknowledge levels into a queue; a monitor pops and compares them against
// what the controller observes on the bus.
module i2c_regbank_target_bench;

    localparam int         HP       = 10;
    localparam logic [6:0] DEV      = 7'h2C;
    localparam int         NREG     = 8;
    localparam int         RO_IDX   = 7;

    typedef struct {
        string      req;
        logic [7:0] val;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic sda_bus;
    logic sda_oe_q = 1'b0;

    int checks = 0;
    int errors = 0;
    int r8_viol = 0;
    bit done = 1'b0;

    exp_t       exp_q[$];
    logic [7:0] obs_q[$];
    logic [7:0] model [NREG];
    int         model_ptr = 0;

    always #10 clk = ~clk;

    assign sda_bus = !(sda_oe || m_low);

    i2c_regbank_target u_i2c_regbank_target (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    // Direct comparison helper.
    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // Scoreboard monitor: pairs expected items with observed ones in order.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && obs_q.size() > 0) begin
                exp_t       e;
                logic [7:0] o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                check(e.req, o, e.val);
            end
        end
    end

    // R8 watch: the target must not start pulling SDA while SCL is high.
    always @(posedge clk) begin
        sda_oe_q <= sda_oe;
        if (rst_n && sda_oe && !sda_oe_q && scl_m)
            r8_viol++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; scl_m = 1'b1; tick(HP);
        m_low = 1'b1; tick(HP);
        scl_m = 1'b0; tick(HP/2);
    endtask

    task automatic bus_rstart();
        m_low = 1'b0; tick(HP/2);
        scl_m = 1'b1; tick(HP);
        m_low = 1'b1; tick(HP);
        scl_m = 1'b0; tick(HP/2);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(HP/2);
        scl_m = 1'b1; tick(HP);
        m_low = 1'b0; tick(HP);
    endtask

    task automatic put_bit(input logic b);
        m_low = !b; tick(HP/2);
        scl_m = 1'b1; tick(HP);
        scl_m = 1'b0; tick(HP/2);
    endtask

    task automatic get_bit(output logic b);
        m_low = 1'b0; tick(HP/2);
        scl_m = 1'b1; tick(HP/2);
        b = sda_bus; tick(HP/2);
        scl_m = 1'b0; tick(HP/2);
    endtask

    // Send a byte; expect acknowledge (line 0) or not (line 1).
    task automatic send_byte(input logic [7:0] v, input string req, input bit exp_ack);
        logic b;
        exp_q.push_back('{req, exp_ack ? 8'h00 : 8'h01});
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        obs_q.push_back({7'b0, b});
    endtask

    // Receive a byte, compare with the model, then answer with ACK or NACK.
    task automatic recv_byte(input bit give_ack, input string req);
        logic [7:0] v;
        logic       b;
        exp_q.push_back('{req, model[model_ptr]});
        model_ptr = (model_ptr + 1) % NREG;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        obs_q.push_back(v);
        put_bit(!give_ack);
    endtask

    task automatic model_write(input logic [7:0] v);
        if (model_ptr != RO_IDX) model[model_ptr] = v;
        model_ptr = (model_ptr + 1) % NREG;
    endtask

    // Full read: optional pointer write and repeated START, then n bytes.
    task automatic txn_read(input bit set_ptr, input int p, input int n, input string req);
        if (set_ptr) begin
            bus_start();
            send_byte({DEV, 1'b0}, "R2 write address ack", 1'b1);
            send_byte(8'(p), "R4 pointer byte ack", 1'b1);
            model_ptr = p;
            bus_rstart();
        end else begin
            bus_start();
        end
        send_byte({DEV, 1'b1}, "R2 read address ack", 1'b1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, req);
        bus_stop();
    endtask

    task automatic wait_drain();
        tick(4);
        check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++)
            model[i] = (i == RO_IDX) ? 8'hC0 + 8'(i) : 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R10: reset state of the pull-down and the line.
        check("R10 sda_oe after reset", {7'b0, sda_oe}, 8'h00);
        check("R10 line idle after reset", {7'b0, sda_bus}, 8'h01);

        // R10 / R6 / R7: read without pointer write starts at index 0.
        txn_read(1'b0, 0, 2, "R10 read from reset pointer");
        wait_drain();

        // R4 / R5: burst write from index 1.
        bus_start();
        send_byte({DEV, 1'b0}, "R2 write address ack", 1'b1);
        send_byte(8'h01, "R4 pointer byte ack", 1'b1);
        model_ptr = 1;
        send_byte(8'h11, "R5 data ack", 1'b1); model_write(8'h11);
        send_byte(8'h22, "R5 data ack", 1'b1); model_write(8'h22);
        send_byte(8'h33, "R5 data ack", 1'b1); model_write(8'h33);
        bus_stop();

        // R6 / R7: combined read of the burst.
        txn_read(1'b1, 1, 3, "R6 burst readback");
        wait_drain();

        // R5 / R9: write across the read-only index and the wrap.
        bus_start();
        send_byte({DEV, 1'b0}, "R2 write address ack", 1'b1);
        send_byte(8'h06, "R4 pointer byte ack", 1'b1);
        model_ptr = 6;
        send_byte(8'h44, "R5 data ack", 1'b1);           model_write(8'h44);
        send_byte(8'h99, "R9 read-only write ack", 1'b1); model_write(8'h99);
        send_byte(8'h55, "R5 wrapped data ack", 1'b1);    model_write(8'h55);
        bus_stop();
        txn_read(1'b1, 6, 3, "R9 R5 read across read-only and wrap");
        wait_drain();

        // R10: pointer kept across STOP.
        bus_start();
        send_byte({DEV, 1'b0}, "R2 write address ack", 1'b1);
        send_byte(8'h02, "R4 pointer-only write ack", 1'b1);
        model_ptr = 2;
        bus_stop();
        txn_read(1'b0, 0, 1, "R10 pointer retained across STOP");
        wait_drain();

        // R3: wrong address and the traffic after it are ignored.
        bus_start();
        send_byte({DEV + 7'd1, 1'b0}, "R3 mismatched address no ack", 1'b0);
        send_byte(8'h05, "R3 ignored byte no ack", 1'b0);
        send_byte(8'hEE, "R3 ignored byte no ack", 1'b0);
        bus_stop();
        txn_read(1'b0, 0, 1, "R3 pointer and data untouched");
        wait_drain();

        // R11: a repeated START halfway through a data byte discards it.
        bus_start();
        send_byte({DEV, 1'b0}, "R2 write address ack", 1'b1);
        send_byte(8'h03, "R4 pointer byte ack", 1'b1);
        model_ptr = 3;
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_rstart();
        send_byte({DEV, 1'b1}, "R2 read address ack", 1'b1);
        recv_byte(1'b0, "R11 aborted byte not written");
        // R7: after NACK the line stays released through further clocks.
        check("R7 released after NACK", {7'b0, sda_oe}, 8'h00);
        put_bit(1'b1);
        check("R7 silent after NACK", {7'b0, sda_oe}, 8'h00);
        bus_stop();
        wait_drain();

        // R8: summary of the drive-timing watch.
        check("R8 drive raised while SCL high", 8'(r8_viol), 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule